// File: doc/BRIEF.md
# Exclusive Two-Level Cache Tag Model

This block is a tag-only model of a two-level cache hierarchy in which the levels are exclusive. A block lives in the first level, in the second level, or in neither, and never in both. Each accepted address is classified as a first-level hit, a second-level hit or a miss in both levels. The classification comes out one cycle later, and four running counters are updated with it. The block keeps no data. Its job is to measure hit and miss behaviour for a chosen geometry, for example while tuning cache sizes.

The first level uses least-recently-used replacement. The second level is filled only by blocks that the first level evicts, and it replaces its entries in the order they arrived. A second-level hit moves the block up into the first level and frees its second-level slot. A block missing in both levels is brought straight into the first level. Both levels share one block size. The number of sets and ways of each level are parameters, and the second level may have fewer, the same number of, or more sets than the first. A slot freed by a promotion stays empty until a later victim maps to that set. Such a victim fills the empty slot before any older entry is displaced.

Top module: `xc_tag_model`

## Requirements
- R1: After reset `res_valid` is low, all four counters read zero and every tag entry is invalid, so the first access to any block is classified as a miss in both levels.
- R2: The result code is 2 bits: 2'b00 means first-level hit, 2'b01 means second-level hit, 2'b10 means miss in both levels; 2'b11 never appears.
- R3: A first-level hit leaves the second level untouched: neither second-level counter changes and no second-level entry is added or removed.
- R4: On a first-level miss that hits in the second level, the block is moved into the first level and removed from the second level, so its next access is a first-level hit.
- R5: On a miss in both levels the block is placed into the first level; a free first-level way is used if one exists, otherwise the least recently used way of that set is evicted.
- R6: A block evicted from the first level is written into the second-level set selected by its own block address; when that set is full, the entry that entered the second level earliest is discarded.
- R7: A second-level slot emptied by a promotion stays empty and is reused by the next victim mapping to that set before any entry of that set is discarded.
- R8: Classification is correct when the second level has fewer, the same number of, or more sets than the first level; set index is the low bits of the block address at each level.
- R9: Counters `l1_hit_cnt`, `l1_miss_cnt`, `l2_hit_cnt`, `l2_miss_cnt` each count their event once per access, updated in the same cycle the result is presented; an L1 miss always also counts as exactly one L2 hit or L2 miss.
- R10: The lowest `OFF_W` address bits (byte within the block) do not affect classification.
- R11: `res_valid` is high in the cycle after each cycle with `req_valid` high and low after each cycle with `req_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle (accepted every cycle) |
| req_addr | input | ADDR_W | Byte address of the access |
| res_valid | output | 1 | Result of the previous cycle's access is valid |
| res_code | output | 2 | Classification: 00 L1 hit, 01 L2 hit, 10 miss in both |
| l1_hit_cnt | output | CNT_W | Accesses that hit in the first level |
| l1_miss_cnt | output | CNT_W | Accesses that missed in the first level |
| l2_hit_cnt | output | CNT_W | First-level misses found in the second level |
| l2_miss_cnt | output | CNT_W | Accesses that missed in both levels |

## Verification
The bench builds three copies side by side, all with a two-set, two-way first level and a two-way second level, and gives the second level one, two and four sets. The same address stream therefore covers the fewer, equal and more sets cases of R8 at once. Two ways per level mean a handful of blocks is enough to force LRU evictions, FIFO discards and slots emptied by promotion whose victim lands in a different set. A long pseudo-random stream over a small block range then revisits these cases many times against an independent timestamp model.

// File: rtl/xc_pkg.sv
package xc_pkg;

   typedef enum logic [1:0] {
      XC_L1_HIT = 2'b00,
      XC_L2_HIT = 2'b01,
      XC_MISS   = 2'b10
   } xc_res_e;

   localparam int XC_NUM_CNT = 4;

endpackage

// File: rtl/xc_rank_upd.sv
// Recency rank update: the touched way becomes rank 0, ways that were
// younger than it move one rank older, older ways keep their rank.
module xc_rank_upd #(
   parameter int WAYS = 2,
   parameter int IW   = 1
) (
   input  logic [WAYS-1:0][IW-1:0] rank_i,
   input  logic [IW-1:0]           touch_i,
   output logic [WAYS-1:0][IW-1:0] rank_o
);

   logic [IW-1:0] touched_rank;

   always_comb begin
      touched_rank = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (touch_i == IW'(w)) touched_rank = rank_i[w];
      end
   end

   for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
      always_comb begin
         if (touch_i == IW'(gw))
            rank_o[gw] = '0;
         else if (rank_i[gw] < touched_rank)
            rank_o[gw] = rank_i[gw] + IW'(1);
         else
            rank_o[gw] = rank_i[gw];
      end
   end

endmodule

// File: rtl/xc_l1_tags.sv
// First level: set-associative tags with LRU replacement.
module xc_l1_tags #(
   parameter int BLK_W    = 14,
   parameter int SETS_LOG = 1,
   parameter int WAYS     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic [BLK_W-1:0] blk_i,
   output logic             hit_o,
   output logic             evict_o,
   output logic [BLK_W-1:0] evict_blk_o
);

   localparam int SETS = 1 << SETS_LOG;
   localparam int SW   = (SETS_LOG > 0) ? SETS_LOG : 1;
   localparam int IW   = (WAYS > 1) ? $clog2(WAYS) : 1;

   logic [BLK_W-1:0]          tag_q [SETS][WAYS];
   logic [WAYS-1:0]           vld_q [SETS];
   logic [WAYS-1:0][IW-1:0]   rank_q [SETS];

   logic [SW-1:0]             set_idx;
   logic [WAYS-1:0]           hit_vec;
   logic [IW-1:0]             hit_way, free_way, lru_way, fill_way, touch_way;
   logic                      has_free;
   logic [WAYS-1:0][IW-1:0]   rank_nxt;

   if (SETS_LOG == 0) begin : g_single_set
      assign set_idx = '0;
   end else begin : g_multi_set
      assign set_idx = blk_i[SETS_LOG-1:0];
   end

   always_comb begin
      hit_vec  = '0;
      hit_way  = '0;
      free_way = '0;
      has_free = 1'b0;
      lru_way  = '0;
      for (int w = 0; w < WAYS; w++) begin
         hit_vec[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == blk_i);
         if (hit_vec[w]) hit_way = IW'(w);
         if (!vld_q[set_idx][w] && !has_free) begin
            has_free = 1'b1;
            free_way = IW'(w);
         end
         if (rank_q[set_idx][w] == IW'(WAYS-1)) lru_way = IW'(w);
      end
   end

   assign hit_o       = |hit_vec;
   assign fill_way    = has_free ? free_way : lru_way;
   assign touch_way   = hit_o ? hit_way : fill_way;
   assign evict_o     = !hit_o && !has_free;
   assign evict_blk_o = tag_q[set_idx][lru_way];

   xc_rank_upd #(.WAYS(WAYS), .IW(IW)) u_rank (
      .rank_i  (rank_q[set_idx]),
      .touch_i (touch_way),
      .rank_o  (rank_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]  <= '0;
               rank_q[s][w] <= IW'(w);
            end
         end
      end else if (acc_en) begin
         rank_q[set_idx] <= rank_nxt;
         if (!hit_o) begin
            tag_q[set_idx][fill_way] <= blk_i;
            vld_q[set_idx][fill_way] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/xc_l2_tags.sv
// Second level: filled only by first-level victims, FIFO replacement,
// entries removed when promoted. Empty slots are kept as invalid ways.
module xc_l2_tags #(
   parameter int BLK_W    = 14,
   parameter int SETS_LOG = 2,
   parameter int WAYS     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             look_en,
   input  logic [BLK_W-1:0] look_blk_i,
   output logic             hit_o,
   input  logic             ins_en,
   input  logic [BLK_W-1:0] ins_blk_i
);

   localparam int SETS = 1 << SETS_LOG;
   localparam int SW   = (SETS_LOG > 0) ? SETS_LOG : 1;
   localparam int IW   = (WAYS > 1) ? $clog2(WAYS) : 1;

   logic [BLK_W-1:0]          tag_q [SETS][WAYS];
   logic [WAYS-1:0]           vld_q [SETS];
   logic [WAYS-1:0][IW-1:0]   rank_q [SETS];

   logic [SW-1:0]             look_set, ins_set;
   logic [WAYS-1:0]           hit_vec, ins_row;
   logic [IW-1:0]             hit_way, free_way, old_way, ins_way;
   logic                      has_free, take;
   logic [WAYS-1:0][IW-1:0]   rank_nxt;

   if (SETS_LOG == 0) begin : g_single_set
      assign look_set = '0;
      assign ins_set  = '0;
   end else begin : g_multi_set
      assign look_set = look_blk_i[SETS_LOG-1:0];
      assign ins_set  = ins_blk_i[SETS_LOG-1:0];
   end

   always_comb begin
      hit_vec = '0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         hit_vec[w] = vld_q[look_set][w] && (tag_q[look_set][w] == look_blk_i);
         if (hit_vec[w]) hit_way = IW'(w);
      end
   end

   assign hit_o = |hit_vec;
   assign take  = look_en && hit_o;

   // Occupancy of the insertion set as it stands after this cycle's removal.
   always_comb begin
      ins_row = vld_q[ins_set];
      if (take && (ins_set == look_set)) ins_row[hit_way] = 1'b0;
      has_free = 1'b0;
      free_way = '0;
      old_way  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!ins_row[w] && !has_free) begin
            has_free = 1'b1;
            free_way = IW'(w);
         end
         if (rank_q[ins_set][w] == IW'(WAYS-1)) old_way = IW'(w);
      end
   end

   assign ins_way = has_free ? free_way : old_way;

   xc_rank_upd #(.WAYS(WAYS), .IW(IW)) u_rank (
      .rank_i  (rank_q[ins_set]),
      .touch_i (ins_way),
      .rank_o  (rank_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]  <= '0;
               rank_q[s][w] <= IW'(w);
            end
         end
      end else begin
         if (take) vld_q[look_set][hit_way] <= 1'b0;
         if (ins_en) begin
            tag_q[ins_set][ins_way] <= ins_blk_i;
            vld_q[ins_set][ins_way] <= 1'b1;
            rank_q[ins_set]         <= rank_nxt;
         end
      end
   end

endmodule

// File: rtl/xc_hit_counters.sv
module xc_hit_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             l1_hit,
   input  logic             l2_hit,
   output logic [CNT_W-1:0] l1_hit_cnt,
   output logic [CNT_W-1:0] l1_miss_cnt,
   output logic [CNT_W-1:0] l2_hit_cnt,
   output logic [CNT_W-1:0] l2_miss_cnt
);

   localparam int N = xc_pkg::XC_NUM_CNT;

   logic [N-1:0]     bump;
   logic [CNT_W-1:0] cnt_q [N];

   assign bump[0] = acc_en && l1_hit;
   assign bump[1] = acc_en && !l1_hit;
   assign bump[2] = acc_en && !l1_hit && l2_hit;
   assign bump[3] = acc_en && !l1_hit && !l2_hit;

   for (genvar gc = 0; gc < N; gc++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)        cnt_q[gc] <= '0;
         else if (bump[gc]) cnt_q[gc] <= cnt_q[gc] + CNT_W'(1);
      end
   end

   assign l1_hit_cnt  = cnt_q[0];
   assign l1_miss_cnt = cnt_q[1];
   assign l2_hit_cnt  = cnt_q[2];
   assign l2_miss_cnt = cnt_q[3];

endmodule

// File: rtl/xc_tag_model.sv
module xc_tag_model #(
   parameter int ADDR_W      = 16,
   parameter int OFF_W       = 2,
   parameter int L1_SETS_LOG = 1,
   parameter int L1_WAYS     = 2,
   parameter int L2_SETS_LOG = 2,
   parameter int L2_WAYS     = 4,
   parameter int CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              res_valid,
   output logic [1:0]        res_code,
   output logic [CNT_W-1:0]  l1_hit_cnt,
   output logic [CNT_W-1:0]  l1_miss_cnt,
   output logic [CNT_W-1:0]  l2_hit_cnt,
   output logic [CNT_W-1:0]  l2_miss_cnt
);

   import xc_pkg::*;

   localparam int BLK_W = ADDR_W - OFF_W;

   initial begin
      assert (OFF_W >= 0 && BLK_W > L1_SETS_LOG && BLK_W > L2_SETS_LOG)
         else $error("xc_tag_model: address too narrow for set index");
      assert (L1_WAYS >= 1 && L2_WAYS >= 1)
         else $error("xc_tag_model: each level needs at least one way");
      assert (L1_SETS_LOG >= 0 && L2_SETS_LOG >= 0 && CNT_W >= 1)
         else $error("xc_tag_model: bad set or counter parameter");
   end

   logic [BLK_W-1:0] blk;
   logic             unused_off;
   logic             l1_hit, l1_evict, l2_hit;
   logic [BLK_W-1:0] l1_evict_blk;
   xc_res_e          code_d;
   xc_res_e          code_q;
   logic             valid_q;

   assign blk        = req_addr[ADDR_W-1:OFF_W];
   assign unused_off = ^{1'b0, req_addr};

   xc_l1_tags #(.BLK_W(BLK_W), .SETS_LOG(L1_SETS_LOG), .WAYS(L1_WAYS)) u_l1 (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_en      (req_valid),
      .blk_i       (blk),
      .hit_o       (l1_hit),
      .evict_o     (l1_evict),
      .evict_blk_o (l1_evict_blk)
   );

   xc_l2_tags #(.BLK_W(BLK_W), .SETS_LOG(L2_SETS_LOG), .WAYS(L2_WAYS)) u_l2 (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_en    (req_valid && !l1_hit),
      .look_blk_i (blk),
      .hit_o      (l2_hit),
      .ins_en     (req_valid && l1_evict),
      .ins_blk_i  (l1_evict_blk)
   );

   xc_hit_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_en      (req_valid),
      .l1_hit      (l1_hit),
      .l2_hit      (l2_hit),
      .l1_hit_cnt  (l1_hit_cnt),
      .l1_miss_cnt (l1_miss_cnt),
      .l2_hit_cnt  (l2_hit_cnt),
      .l2_miss_cnt (l2_miss_cnt)
   );

   always_comb begin
      if (l1_hit)      code_d = XC_L1_HIT;
      else if (l2_hit) code_d = XC_L2_HIT;
      else             code_d = XC_MISS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         code_q  <= XC_MISS;
      end else begin
         valid_q <= req_valid;
         if (req_valid) code_q <= code_d;
      end
   end

   assign res_valid = valid_q;
   assign res_code  = code_q;

endmodule

// File: rtl/xc_tag_model_checker.sv
module xc_tag_model_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             res_valid,
   input logic [1:0]       res_code,
   input logic [CNT_W-1:0] l1_hit_cnt,
   input logic [CNT_W-1:0] l1_miss_cnt,
   input logic [CNT_W-1:0] l2_hit_cnt,
   input logic [CNT_W-1:0] l2_miss_cnt
);

   a_r11_res_after_req : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   a_r11_no_res_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   a_r2_code_legal : assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code != 2'b11));

   a_r3_l1_hit_spares_l2 : assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'b00) |-> ($stable(l2_hit_cnt) && $stable(l2_miss_cnt)));

   a_r4_l2_hit_counted : assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'b01) |->
         (l2_hit_cnt == $past(l2_hit_cnt) + CNT_W'(1) && $stable(l2_miss_cnt)));

   a_r5_miss_counted : assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'b10) |->
         (l2_miss_cnt == $past(l2_miss_cnt) + CNT_W'(1) && $stable(l2_hit_cnt)));

   a_r9_one_count_per_access : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (CNT_W'(l1_hit_cnt + l1_miss_cnt) ==
                     CNT_W'($past(l1_hit_cnt) + $past(l1_miss_cnt) + CNT_W'(1))));

   a_r9_l2_splits_l1_miss : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($stable(l1_miss_cnt) ==
                     ($stable(l2_hit_cnt) && $stable(l2_miss_cnt))));

endmodule

bind xc_tag_model xc_tag_model_checker #(.CNT_W(CNT_W)) u_xc_tag_model_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .res_valid   (res_valid),
   .res_code    (res_code),
   .l1_hit_cnt  (l1_hit_cnt),
   .l1_miss_cnt (l1_miss_cnt),
   .l2_hit_cnt  (l2_hit_cnt),
   .l2_miss_cnt (l2_miss_cnt)
);

// File: tb/xc_tag_model_bench.sv
`timescale 1ns/1ps
module xc_tag_model_bench;

   localparam int NI     = 3;
   localparam int ADDR_W = 16;
   localparam int OFF_W  = 2;
   localparam int CNT_W  = 16;
   localparam int S1     = 2;   // first-level sets
   localparam int W1     = 2;
   localparam int S2MAX  = 4;
   localparam int W2     = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;

   logic              rv   [NI];
   logic [1:0]        rc   [NI];
   logic [CNT_W-1:0]  c_l1h[NI], c_l1m[NI], c_l2h[NI], c_l2m[NI];

   always #2.5 clk = ~clk;

   for (genvar gi = 0; gi < NI; gi++) begin : g_dut
      xc_tag_model #(
         .ADDR_W(ADDR_W), .OFF_W(OFF_W), .L1_SETS_LOG(1), .L1_WAYS(W1),
         .L2_SETS_LOG(gi), .L2_WAYS(W2), .CNT_W(CNT_W)
      ) u_xc_tag_model (
         .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
         .res_valid(rv[gi]), .res_code(rc[gi]),
         .l1_hit_cnt(c_l1h[gi]), .l1_miss_cnt(c_l1m[gi]),
         .l2_hit_cnt(c_l2h[gi]), .l2_miss_cnt(c_l2m[gi])
      );
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // ---------------- reference model (timestamps) ----------------
   int m1_blk [NI][S1][W1];
   bit m1_v   [NI][S1][W1];
   int m1_ts  [NI][S1][W1];
   int m2_blk [NI][S2MAX][W2];
   bit m2_v   [NI][S2MAX][W2];
   int m2_ts  [NI][S2MAX][W2];
   int e_l1h[NI], e_l1m[NI], e_l2h[NI], e_l2m[NI];
   int tick = 0;

   function automatic int l2_sets(input int k);
      return 1 << k;
   endfunction

   task automatic model_step(input int k, input int blk, output logic [1:0] code);
      int s1, s2, slot, vb;
      bit ev;
      s1 = blk % S1;
      tick++;
      code = 2'b10;
      for (int w = 0; w < W1; w++)
         if (m1_v[k][s1][w] && m1_blk[k][s1][w] == blk) begin
            code = 2'b00;
            m1_ts[k][s1][w] = tick;
         end
      if (code == 2'b00) begin
         e_l1h[k]++;
         return;
      end
      e_l1m[k]++;
      s2 = blk % l2_sets(k);
      for (int w = 0; w < W2; w++)
         if (m2_v[k][s2][w] && m2_blk[k][s2][w] == blk) begin
            m2_v[k][s2][w] = 1'b0;
            code = 2'b01;
         end
      if (code == 2'b01) e_l2h[k]++;
      else               e_l2m[k]++;
      slot = -1;
      for (int w = 0; w < W1; w++) if (!m1_v[k][s1][w] && slot < 0) slot = w;
      ev = 1'b0;
      vb = 0;
      if (slot < 0) begin
         slot = 0;
         for (int w = 1; w < W1; w++) if (m1_ts[k][s1][w] < m1_ts[k][s1][slot]) slot = w;
         ev = 1'b1;
         vb = m1_blk[k][s1][slot];
      end
      m1_blk[k][s1][slot] = blk;
      m1_v[k][s1][slot]   = 1'b1;
      m1_ts[k][s1][slot]  = tick;
      if (ev) begin
         s2 = vb % l2_sets(k);
         slot = -1;
         for (int w = 0; w < W2; w++) if (!m2_v[k][s2][w] && slot < 0) slot = w;
         if (slot < 0) begin
            slot = 0;
            for (int w = 1; w < W2; w++) if (m2_ts[k][s2][w] < m2_ts[k][s2][slot]) slot = w;
         end
         m2_blk[k][s2][slot] = vb;
         m2_v[k][s2][slot]   = 1'b1;
         m2_ts[k][s2][slot]  = tick;
      end
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      int         k;
      logic [1:0] code;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   task automatic access(input int blk, input int off, input string tag);
      logic [1:0] c;
      exp_t it;
      for (int k = 0; k < NI; k++) begin
         model_step(k, blk, c);
         it.k = k; it.code = c; it.tag = tag;
         exp_q.push_back(it);
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(blk * (1 << OFF_W) + off);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && rv[0]) begin
         for (int k = 0; k < NI; k++) begin
            exp_t it;
            if (exp_q.size() == 0) begin
               check(1'b0, "R11", "unexpected result", int'(rc[k]), -1);
            end else begin
               it = exp_q.pop_front();
               check(rv[it.k] == 1'b1, "R11", "res_valid lane", int'(rv[it.k]), 1);
               check(rc[it.k] == it.code, it.tag, $sformatf("res_code inst%0d", it.k),
                     int'(rc[it.k]), int'(it.code));
            end
         end
      end
   end

   bit finished = 1'b0;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         check(1'b0, "R11", "watchdog expired", 0, 1);
         summary();
      end
   end

   initial begin
      int lcg;
      int blk;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int k = 0; k < NI; k++) begin
         check(rv[k] == 1'b0, "R1", "res_valid in reset", int'(rv[k]), 0);
         check(c_l1h[k] == 0 && c_l1m[k] == 0 && c_l2h[k] == 0 && c_l2m[k] == 0,
               "R1", "counters in reset", int'(c_l1h[k] + c_l1m[k] + c_l2h[k] + c_l2m[k]), 0);
      end
      rst_n = 1'b1;
      idle(1);

      // R1/R2: cold accesses miss in both levels
      access(0, 0, "R1");
      access(2, 1, "R2");
      // R3 / R10: hit on a different byte offset of the same block
      access(0, 3, "R10");
      // R5: set 0 full, LRU is block 2 -> evicted into L2
      access(4, 0, "R5");
      access(0, 2, "R5");
      // R4: block 2 comes back from L2 and leaves it
      access(2, 0, "R4");
      access(2, 1, "R4");
      access(4, 0, "R4");
      access(0, 0, "R3");
      // R6/R7: more victims into sets of different second-level shapes
      access(6, 0, "R6");
      access(8, 0, "R6");
      access(10, 0, "R6");
      access(12, 0, "R6");
      access(2, 0, "R7");
      access(14, 0, "R7");
      access(6, 0, "R7");
      access(4, 0, "R7");
      access(1, 0, "R8");
      access(3, 0, "R8");
      access(5, 0, "R8");
      access(1, 0, "R8");
      idle(2);
      // R11: no request -> no result
      for (int k = 0; k < NI; k++)
         check(rv[k] == 1'b0, "R11", "res_valid idle", int'(rv[k]), 0);

      // R8: long pseudo-random stream over a small block range
      lcg = 12345;
      for (int i = 0; i < 600; i++) begin
         lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
         blk = (lcg >> 8) % 12;
         access(blk, (lcg >> 4) & 3, "R8");
         if (((lcg >> 20) & 7) == 0) idle(1);
      end
      idle(3);

      // R9: counters against the model
      for (int k = 0; k < NI; k++) begin
         check(int'(c_l1h[k]) == e_l1h[k], "R9", $sformatf("l1_hit_cnt inst%0d", k), int'(c_l1h[k]), e_l1h[k]);
         check(int'(c_l1m[k]) == e_l1m[k], "R9", $sformatf("l1_miss_cnt inst%0d", k), int'(c_l1m[k]), e_l1m[k]);
         check(int'(c_l2h[k]) == e_l2h[k], "R9", $sformatf("l2_hit_cnt inst%0d", k), int'(c_l2h[k]), e_l2h[k]);
         check(int'(c_l2m[k]) == e_l2m[k], "R9", $sformatf("l2_miss_cnt inst%0d", k), int'(c_l2m[k]), e_l2m[k]);
      end
      check(exp_q.size() == 0, "R11", "results outstanding", exp_q.size(), 0);
      finished = 1'b1;
      summary();
   end

endmodule